// File: doc/BRIEF.md
# Hunt-Gated UART Receiver

This block deframes an asynchronous serial line and passes received characters to the rest of the chip. Delivery is gated by a hunt state. While the receiver hunts, it drops every character. It leaves the hunt state only when the line shows a point where it can resynchronise. A mode input picks that point: either a full character time of idle (high) line, or a character whose extra address bit is set. Out of reset the receiver is hunting. A one-cycle command puts it back into the hunt state at any time, and the character being received at that moment is discarded.

The line is sampled on a 16x oversampling tick that the surrounding logic supplies. A frame is a low start bit, eight data bits sent LSB first, an optional address bit and a stop bit. A break is a frame that is zero from the start bit to the stop bit. A break raises a one-cycle event and increments a saturating counter. This happens whether or not the receiver is hunting. Software clears the counter through a synchronous clear input. A frame whose stop bit is zero but that is not a break is delivered with a framing-error flag when the receiver is not hunting.

Top module: `uart_hunt_rx`

## Requirements
- R1: After reset, hunting is 1, rx_valid and brk_evt are 0 and brk_cnt is 0.
- R2: A frame is one low start bit, then 8 data bits LSB first, then the address bit when addr_en=1, then the stop bit. Each bit lasts 16 ticks and is sampled near its middle. A delivered character appears as a one-cycle rx_valid pulse, with rx_data holding the data byte.
- R3: While hunting is 1, no character is delivered, except the wakeup character of R5.
- R4: With wake_sel=0 (idle wakeup), hunting drops once the line has stayed high for 16x(10+addr_en) consecutive ticks. A shorter high stretch leaves hunting at 1.
- R5: With wake_sel=1 (address wakeup), a frame with the address bit 1 and the stop bit 1 clears hunting. That frame is delivered with rx_addr=1 and rx_ferr=0. Frames with the address bit 0, and idle stretches of any length, leave hunting at 1.
- R6: A one-cycle enter_hunt sets hunting to 1 in the next cycle. The frame in progress is discarded, and the idle-time count starts again from zero.
- R7: A break is a frame whose data bits, address bit and stop bit are all zero. It pulses brk_evt for one cycle and increments brk_cnt, in any state. It is never delivered. After a break, or after any zero stop bit, the line must go high before a new start bit is accepted, so a held-low line counts as one break.
- R8: brk_cnt is CNT_W bits wide (default 16) and stays at all ones once it gets there.
- R9: brk_clr makes brk_cnt 0 in the next cycle, and it takes precedence over an increment.
- R10: When hunting is 0, a frame with a zero stop bit that is not a break is delivered with rx_ferr=1. Such a frame never acts as a wakeup character.
- R11: When hunting is 0, rx_addr carries the received address bit of each delivered frame. It is 0 when addr_en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| addr_en | input | 1 | 1 adds an address bit after the data bits |
| wake_sel | input | 1 | 0 = wake on idle line, 1 = wake on address character |
| enter_hunt | input | 1 | One-cycle command that forces the hunt state |
| brk_clr | input | 1 | Synchronous clear of the break counter |
| rx_valid | output | 1 | One-cycle pulse for a delivered character |
| rx_data | output | 8 | Delivered data byte |
| rx_addr | output | 1 | Address bit of the delivered character |
| rx_ferr | output | 1 | Framing error on the delivered character |
| brk_evt | output | 1 | One-cycle pulse per detected break |
| brk_cnt | output | CNT_W | Saturating break counter |
| hunting | output | 1 | 1 while characters are being suppressed |

## Verification
Several rules are checked by assertions on every cycle. No delivery happens while the hunt state is held. The enter command takes effect one cycle later and blocks a delivery in that cycle. The break counter moves only on a break event or a clear, holds at saturation, and clears one cycle after brk_clr. A character delivered in the cycle the hunt state ends must carry the address flag. The bench scenarios cover what no single-cycle property can show. These are the exact length of idle time that ends the hunt, and the restart of that count by the command. They also cover the bit order and sampling point of the deframer, the one-break-per-low-stretch rule, and the rule that a frame with a bad stop bit never wakes the receiver.

// File: rtl/uhr_pkg.sv
package uhr_pkg;

  typedef enum logic [2:0] {
    FR_IDLE  = 3'd0,
    FR_START = 3'd1,
    FR_DATA  = 3'd2,
    FR_STOP  = 3'd3,
    FR_WAITH = 3'd4
  } fr_state_t;

endpackage

// File: rtl/uhr_sync.sv
module uhr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_n;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/uhr_framer.sv
module uhr_framer
  import uhr_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OVS       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rx,
  input  logic                 abort,
  input  logic                 addr_en,
  output logic                 done,
  output logic                 stop_ok,
  output logic [DATA_BITS-1:0] data,
  output logic                 abit
);

  localparam int PW  = $clog2(OVS);
  localparam int SW  = DATA_BITS + 1;
  localparam int IW  = $clog2(DATA_BITS + 2);
  localparam logic [PW-1:0] PH_MID  = PW'(OVS/2 - 1);
  localparam logic [PW-1:0] PH_LAST = PW'(OVS - 1);

  fr_state_t      st_q, st_n;
  logic [PW-1:0]  ph_q, ph_n;
  logic [IW-1:0]  idx_q, idx_n;
  logic [SW-1:0]  sh_q, sh_n;
  logic           done_q, done_n;
  logic           stop_q, stop_n;
  logic           adv;
  logic [IW-1:0]  idx_end;

  assign adv     = tick | abort;
  assign idx_end = addr_en ? IW'(DATA_BITS) : IW'(DATA_BITS - 1);

  always_comb begin
    st_n   = st_q;
    ph_n   = ph_q;
    idx_n  = idx_q;
    sh_n   = sh_q;
    done_n = 1'b0;
    stop_n = stop_q;
    if (abort) begin
      st_n = FR_IDLE;
      ph_n = '0;
    end else if (tick) begin
      unique case (st_q)
        FR_IDLE: begin
          if (!rx) begin
            st_n = FR_START;
            ph_n = '0;
          end
        end
        FR_START: begin
          if (ph_q == PH_MID) begin
            ph_n  = '0;
            idx_n = '0;
            st_n  = rx ? FR_IDLE : FR_DATA;
          end else begin
            ph_n = ph_q + 1'b1;
          end
        end
        FR_DATA: begin
          if (ph_q == PH_LAST) begin
            ph_n  = '0;
            sh_n  = {rx, sh_q[SW-1:1]};
            idx_n = idx_q + 1'b1;
            if (idx_q == idx_end) st_n = FR_STOP;
          end else begin
            ph_n = ph_q + 1'b1;
          end
        end
        FR_STOP: begin
          if (ph_q == PH_LAST) begin
            ph_n   = '0;
            done_n = 1'b1;
            stop_n = rx;
            st_n   = rx ? FR_IDLE : FR_WAITH;
          end else begin
            ph_n = ph_q + 1'b1;
          end
        end
        FR_WAITH: begin
          if (rx) st_n = FR_IDLE;
        end
        default: st_n = FR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_IDLE;
      ph_q   <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      stop_q <= 1'b1;
    end else if (adv) begin
      st_q   <= st_n;
      ph_q   <= ph_n;
      idx_q  <= idx_n;
      sh_q   <= sh_n;
      stop_q <= stop_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_n;
  end

  assign done    = done_q;
  assign stop_ok = stop_q;
  assign data    = addr_en ? sh_q[DATA_BITS-1:0] : sh_q[SW-1:1];
  assign abit    = addr_en & sh_q[SW-1];

endmodule

// File: rtl/uhr_idle.sv
module uhr_idle #(
  parameter int DATA_BITS = 8,
  parameter int OVS       = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx,
  input  logic restart,
  input  logic addr_en,
  output logic idle_hit
);

  localparam int TERM_S = OVS * (DATA_BITS + 2);
  localparam int TERM_L = OVS * (DATA_BITS + 3);
  localparam int CW     = $clog2(TERM_L + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          hit_q, hit_n;
  logic [CW-1:0] term;

  assign term = addr_en ? CW'(TERM_L) : CW'(TERM_S);

  always_comb begin
    cnt_n = cnt_q;
    hit_n = 1'b0;
    if (restart) begin
      cnt_n = '0;
    end else if (tick) begin
      if (!rx) begin
        cnt_n = '0;
      end else if (cnt_q < term) begin
        cnt_n = cnt_q + 1'b1;
        hit_n = (cnt_q == term - 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (tick | restart) cnt_q <= cnt_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_n;
  end

  assign idle_hit = hit_q;

endmodule

// File: rtl/uhr_hunt.sv
module uhr_hunt #(
  parameter int DATA_BITS = 8,
  parameter int CNT_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fr_done,
  input  logic                 fr_stop_ok,
  input  logic [DATA_BITS-1:0] fr_data,
  input  logic                 fr_abit,
  input  logic                 idle_hit,
  input  logic                 enter_hunt,
  input  logic                 wake_sel,
  input  logic                 brk_clr,
  output logic                 rx_valid,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_addr,
  output logic                 rx_ferr,
  output logic                 brk_evt,
  output logic [CNT_W-1:0]     brk_cnt,
  output logic                 hunting
);

  logic                 hunt_q, hunt_n;
  logic                 vld_q, vld_n;
  logic [DATA_BITS-1:0] dat_q, dat_n;
  logic                 adr_q, adr_n;
  logic                 fer_q, fer_n;
  logic                 evt_q, evt_n;
  logic [CNT_W-1:0]     cnt_q, cnt_n;
  logic                 is_brk;
  logic                 is_wake;

  assign is_brk  = fr_done & ~fr_stop_ok & ~fr_abit & (fr_data == '0);
  assign is_wake = wake_sel & fr_abit & fr_stop_ok;

  always_comb begin
    hunt_n = hunt_q;
    vld_n  = 1'b0;
    dat_n  = dat_q;
    adr_n  = 1'b0;
    fer_n  = 1'b0;
    evt_n  = 1'b0;
    if (enter_hunt) begin
      hunt_n = 1'b1;
    end else if (fr_done) begin
      if (is_brk) begin
        evt_n = 1'b1;
      end else if (!hunt_q || is_wake) begin
        hunt_n = 1'b0;
        vld_n  = 1'b1;
        dat_n  = fr_data;
        adr_n  = fr_abit;
        fer_n  = ~fr_stop_ok;
      end
    end else if (hunt_q && !wake_sel && idle_hit) begin
      hunt_n = 1'b0;
    end
  end

  always_comb begin
    cnt_n = cnt_q;
    if (brk_clr)                    cnt_n = '0;
    else if (evt_n && cnt_q != '1)  cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hunt_q <= 1'b1;
      vld_q  <= 1'b0;
      adr_q  <= 1'b0;
      fer_q  <= 1'b0;
      evt_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      hunt_q <= hunt_n;
      vld_q  <= vld_n;
      adr_q  <= adr_n;
      fer_q  <= fer_n;
      evt_q  <= evt_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dat_q <= '0;
    else if (vld_n) dat_q <= dat_n;
  end

  assign rx_valid = vld_q;
  assign rx_data  = dat_q;
  assign rx_addr  = adr_q;
  assign rx_ferr  = fer_q;
  assign brk_evt  = evt_q;
  assign brk_cnt  = cnt_q;
  assign hunting  = hunt_q;

endmodule

// File: rtl/uart_hunt_rx.sv
module uart_hunt_rx #(
  parameter int DATA_BITS   = 8,
  parameter int OVS         = 16,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick16,
  input  logic                 rxd,
  input  logic                 addr_en,
  input  logic                 wake_sel,
  input  logic                 enter_hunt,
  input  logic                 brk_clr,
  output logic                 rx_valid,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_addr,
  output logic                 rx_ferr,
  output logic                 brk_evt,
  output logic [CNT_W-1:0]     brk_cnt,
  output logic                 hunting
);

  logic [1:0]           rst_pipe_q;
  logic                 rst_s;
  logic                 rx_s;
  logic                 fr_done;
  logic                 fr_stop_ok;
  logic [DATA_BITS-1:0] fr_data;
  logic                 fr_abit;
  logic                 idle_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s = rst_pipe_q[1];

  uhr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_s),
    .d     (rxd),
    .q     (rx_s)
  );

  uhr_framer #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_framer (
    .clk     (clk),
    .rst_n   (rst_s),
    .tick    (tick16),
    .rx      (rx_s),
    .abort   (enter_hunt),
    .addr_en (addr_en),
    .done    (fr_done),
    .stop_ok (fr_stop_ok),
    .data    (fr_data),
    .abit    (fr_abit)
  );

  uhr_idle #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_idle (
    .clk      (clk),
    .rst_n    (rst_s),
    .tick     (tick16),
    .rx       (rx_s),
    .restart  (enter_hunt),
    .addr_en  (addr_en),
    .idle_hit (idle_hit)
  );

  uhr_hunt #(.DATA_BITS(DATA_BITS), .CNT_W(CNT_W)) u_hunt (
    .clk        (clk),
    .rst_n      (rst_s),
    .fr_done    (fr_done),
    .fr_stop_ok (fr_stop_ok),
    .fr_data    (fr_data),
    .fr_abit    (fr_abit),
    .idle_hit   (idle_hit),
    .enter_hunt (enter_hunt),
    .wake_sel   (wake_sel),
    .brk_clr    (brk_clr),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_addr    (rx_addr),
    .rx_ferr    (rx_ferr),
    .brk_evt    (brk_evt),
    .brk_cnt    (brk_cnt),
    .hunting    (hunting)
  );

endmodule

// File: rtl/uhr_chk.sv
module uhr_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_s,
  input logic             enter_hunt,
  input logic             brk_clr,
  input logic             rx_valid,
  input logic             rx_addr,
  input logic             rx_ferr,
  input logic             brk_evt,
  input logic [CNT_W-1:0] brk_cnt,
  input logic             hunting
);

  // R3
  no_delivery_in_hunt_chk: assert property (@(posedge clk) disable iff (!rst_s)
    rx_valid |-> !hunting);

  // R6
  enter_forces_hunt_chk: assert property (@(posedge clk) disable iff (!rst_s)
    enter_hunt |=> (hunting && !rx_valid));

  // R5
  wake_char_tagged_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (rx_valid && $past(hunting)) |-> (rx_addr && !rx_ferr));

  // R7
  break_not_delivered_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0({rx_valid, brk_evt}));

  // R7
  count_moves_on_event_chk: assert property (@(posedge clk) disable iff (!rst_s)
    1'b1 |=> (brk_evt || $past(brk_clr) || $stable(brk_cnt)));

  // R8
  count_saturates_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (brk_cnt == '1 && !brk_clr) |=> (brk_cnt == '1));

  // R9
  clear_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_s)
    brk_clr |=> (brk_cnt == '0));

endmodule

bind uart_hunt_rx uhr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_s      (rst_s),
  .enter_hunt (enter_hunt),
  .brk_clr    (brk_clr),
  .rx_valid   (rx_valid),
  .rx_addr    (rx_addr),
  .rx_ferr    (rx_ferr),
  .brk_evt    (brk_evt),
  .brk_cnt    (brk_cnt),
  .hunting    (hunting)
);

// File: tb/uart_hunt_rx_test.sv
module uart_hunt_rx_test;

  localparam int CW = 3;

  logic          clk;
  logic          rst_n;
  logic          tick16;
  logic          rxd;
  logic          addr_en;
  logic          wake_sel;
  logic          enter_hunt;
  logic          brk_clr;
  logic          rx_valid;
  logic [7:0]    rx_data;
  logic          rx_addr;
  logic          rx_ferr;
  logic          brk_evt;
  logic [CW-1:0] brk_cnt;
  logic          hunting;

  int checks = 0;
  int errors = 0;
  int brk_seen = 0;
  bit finished = 0;
  logic [1:0] div_q;

  typedef struct packed { logic [7:0] d; logic a; logic f; } item_t;
  item_t expq[$];

  uart_hunt_rx #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .addr_en(addr_en), .wake_sel(wake_sel), .enter_hunt(enter_hunt),
    .brk_clr(brk_clr), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_addr(rx_addr), .rx_ferr(rx_ferr), .brk_evt(brk_evt),
    .brk_cnt(brk_cnt), .hunting(hunting)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= 2'd0;
    else        div_q <= div_q + 2'd1;
  end
  assign tick16 = rst_n && (div_q == 2'd3);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!tick16) @(negedge clk);
    end
  endtask

  task automatic pulse_hunt();
    enter_hunt = 1'b1;
    @(negedge clk);
    enter_hunt = 1'b0;
    check(hunting == 1'b1, "R6 hunt after command", hunting, 1);
  endtask

  task automatic expect_char(input logic [7:0] d, input logic a, input logic f);
    expq.push_back({d, a, f});
  endtask

  task automatic send_char(input logic [7:0] d, input logic a, input logic s, input int abort_at);
    rxd = 1'b0;
    wait_ticks(16);
    for (int b = 0; b < 8; b++) begin
      if (b == abort_at) pulse_hunt();
      rxd = d[b];
      wait_ticks(16);
    end
    if (addr_en) begin
      rxd = a;
      wait_ticks(16);
    end
    rxd = s;
    wait_ticks(16);
    rxd = 1'b1;
    if (!s) wait_ticks(2);
  endtask

  always @(negedge clk) begin
    if (rst_n && brk_evt) brk_seen++;
    if (rst_n && rx_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R3 unexpected delivery", rx_data, 0);
      end else begin
        item_t e;
        e = expq.pop_front();
        check(rx_data == e.d, "R2 data", rx_data, e.d);
        check(rx_addr == e.a, "R11 address flag", rx_addr, e.a);
        check(rx_ferr == e.f, "R10 framing flag", rx_ferr, e.f);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rxd = 1'b1; addr_en = 1'b0; wake_sel = 1'b0;
    enter_hunt = 1'b0; brk_clr = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check(hunting == 1'b1, "R1 hunting", hunting, 1);
    check(rx_valid == 1'b0, "R1 valid", rx_valid, 0);
    check(brk_cnt == '0, "R1 count", brk_cnt, 0);
    check(brk_evt == 1'b0, "R1 event", brk_evt, 0);

    // R3: suppressed while hunting, R4: short gap keeps hunting
    wait_ticks(2);
    send_char(8'h41, 1'b0, 1'b1, -1);
    wait_ticks(80);
    check(hunting == 1'b1, "R4 short gap", hunting, 1);
    wait_ticks(170);
    check(hunting == 1'b0, "R4 idle wakeup", hunting, 0);

    // R2: several patterns
    expect_char(8'h5A, 1'b0, 1'b0); send_char(8'h5A, 1'b0, 1'b1, -1);
    expect_char(8'hA5, 1'b0, 1'b0); send_char(8'hA5, 1'b0, 1'b1, -1);
    expect_char(8'hFF, 1'b0, 1'b0); send_char(8'hFF, 1'b0, 1'b1, -1);
    expect_char(8'h01, 1'b0, 1'b0); send_char(8'h01, 1'b0, 1'b1, -1);
    // R10: framing error delivered
    expect_char(8'h33, 1'b0, 1'b1); send_char(8'h33, 1'b0, 1'b0, -1);
    wait_ticks(16);

    // R7: break outside hunt
    send_char(8'h00, 1'b0, 1'b0, -1);
    wait_ticks(16);
    check(brk_cnt == 3'd1, "R7 break count", brk_cnt, 1);
    check(brk_seen == 1, "R7 break event", brk_seen, 1);
    // R7: held low counts once
    rxd = 1'b0;
    wait_ticks(16 * 25);
    rxd = 1'b1;
    wait_ticks(32);
    check(brk_cnt == 3'd2, "R7 held low one break", brk_cnt, 2);

    // R6: abort mid-frame, then suppressed frame, R7 break while hunting
    send_char(8'hF0, 1'b0, 1'b1, 4);
    send_char(8'h12, 1'b0, 1'b1, -1);
    wait_ticks(48);
    send_char(8'h00, 1'b0, 1'b0, -1);
    wait_ticks(16);
    check(brk_cnt == 3'd3, "R7 break in hunt", brk_cnt, 3);
    check(brk_seen == 3, "R7 event in hunt", brk_seen, 3);
    wait_ticks(60);
    check(hunting == 1'b1, "R4 still hunting", hunting, 1);
    wait_ticks(120);
    check(hunting == 1'b0, "R4 idle after break", hunting, 0);
    // R6: command restarts idle count on an already idle line
    wait_ticks(20);
    pulse_hunt();
    wait_ticks(100);
    check(hunting == 1'b1, "R6 idle count restarted", hunting, 1);
    wait_ticks(80);
    check(hunting == 1'b0, "R6 idle wakeup after restart", hunting, 0);

    // R5: address wakeup
    addr_en = 1'b1; wake_sel = 1'b1;
    wait_ticks(4);
    pulse_hunt();
    send_char(8'h10, 1'b0, 1'b1, -1);
    wait_ticks(250);
    check(hunting == 1'b1, "R5 idle ignored", hunting, 1);
    send_char(8'h7E, 1'b1, 1'b0, -1);
    wait_ticks(16);
    check(hunting == 1'b1, "R10 bad stop no wake", hunting, 1);
    expect_char(8'h7E, 1'b1, 1'b0); send_char(8'h7E, 1'b1, 1'b1, -1);
    wait_ticks(2);
    check(hunting == 1'b0, "R5 address wakeup", hunting, 0);
    // R11
    expect_char(8'h11, 1'b0, 1'b0); send_char(8'h11, 1'b0, 1'b1, -1);
    expect_char(8'h22, 1'b1, 1'b0); send_char(8'h22, 1'b1, 1'b1, -1);
    expect_char(8'h00, 1'b1, 1'b0); send_char(8'h00, 1'b1, 1'b1, -1);
    wait_ticks(4);

    // R9
    brk_clr = 1'b1;
    @(negedge clk);
    brk_clr = 1'b0;
    check(brk_cnt == '0, "R9 clear", brk_cnt, 0);

    // R8: saturation (count width 3 in this bench)
    for (int k = 0; k < 8; k++) send_char(8'h00, 1'b0, 1'b0, -1);
    wait_ticks(16);
    check(brk_cnt == 3'd7, "R8 saturated", brk_cnt, 7);
    check(brk_seen == 11, "R7 total events", brk_seen, 11);

    wait_ticks(8);
    check(expq.size() == 0, "R2 all expected delivered", expq.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule